// File: doc/BRIEF.md
# Triple-Precision Digit-Serial Accumulator

This block is the accumulate stage of one tap in a transposed-form, digit-serial FIR filter. Operands arrive least significant digit first, `DIGIT_W` bits per clock. A `WORD_W`-bit word therefore spans `WORD_W/DIGIT_W` cycles, and words follow one another with no idle cycles. Three chained adder cells each handle one 8-bit precision word of a 24-bit running sum:

- The low cell adds the multiplier's low product word to the low word of the previous tap's partial sum.
- The middle cell adds the multiplier's high product word to the middle partial-sum word.
- The top cell adds a sign-extension word to the high partial-sum word. The sign-extension word is built from a sign bit that was latched from the product.

The three cells work on three different samples in the same cycle. The middle-word streams trail the low-word streams by one word period, and the high-word streams trail by two. Because of this skew, a carry that leaves a cell at the end of a word enters the next cell at the start of that sample's next word.

Two framing strobes come from outside the block. One marks the first digit of every word and the other marks the last digit. The multiplier, the tap delay lines and the strobe generator are not part of this block.

Top module: `dsa_accum`

## Requirements
- R1: Each operand is a sequence of `WORD_W/DIGIT_W` digits, least significant first, with no gap between words. `firstDigit` is high on digit 0 of every word and `lastDigit` is high on the final digit. When a word is a single digit, both strobes are high on it.
- R2: Each output digit appears on the sum outputs one clock after the input digits it was computed from.
- R3: On every digit except the first digit of a word, each cell adds its own registered carry from the previous cycle. This ripples the carry along a word.
- R4: On the first digit of a word, the low cell uses a carry-in of 0. The middle cell uses the low cell's carry-out from the previous cycle, and the top cell uses the middle cell's carry-out from the previous cycle.
- R5: The low-word input streams carry the low byte of sample k during word period k. The middle-word streams carry sample k during period k+1, and the high-word streams carry sample k during period k+2. With this alignment, the three output words of sample k form bits 0-7, 8-15 and 16-23 of (partial + sign-extended product).
- R6: On a cycle where `lastDigit` is high, bit `DIGIT_W-1` of `prodHighDigit` is captured as the product sign. Throughout the following word, every bit of the top cell's addend digit equals that captured sign.
- R7: The carry out of the top cell is dropped, so the 24-bit result wraps modulo 2^24.
- R8: A synchronous, active-high `rst` clears all carry registers, the sign latch and all three sum outputs to zero on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| firstDigit | input | 1 | High on the first digit of every word |
| lastDigit | input | 1 | High on the last digit of every word |
| prodLowDigit | input | DIGIT_W | Digit of the product low word |
| prodHighDigit | input | DIGIT_W | Digit of the product high word (one period behind the low word) |
| partLowDigit | input | DIGIT_W | Digit of the previous tap's low partial-sum word |
| partMidDigit | input | DIGIT_W | Digit of the previous tap's middle partial-sum word |
| partHighDigit | input | DIGIT_W | Digit of the previous tap's high partial-sum word |
| sumLowDigit | output | DIGIT_W | Registered low-word sum digit |
| sumMidDigit | output | DIGIT_W | Registered middle-word sum digit |
| sumHighDigit | output | DIGIT_W | Registered high-word sum digit |

## Verification
Most internal faults show up as a wrong byte in the reassembled 24-bit result one word period after the sample enters the affected cell:

- A carry register that is stale or cleared at the wrong time corrupts the low or middle byte within the same word, or the next byte one word later.
- A boundary carry routed to the wrong cell shows up in the next byte of the same sample one word period later.
- A sign latch that is loaded on the wrong digit, or not held, damages the top byte of a negative-product sample two periods after its low word.

Carry ripples that cross all three cells, wraparound, alternating signs and back-to-back samples keep these paths exercised.

// File: rtl/dsa_pkg.sv
package dsa_pkg;

  // Number of precision cells chained in the accumulator.
  localparam int CELL_COUNT = 3;

  // Strobes the framing control hands to the datapath.
  typedef struct packed {
    logic wordStart;  // first digit of a word: take carry from the cell below
    logic signLoad;   // last digit of a word: capture product sign
  } strobe_t;

endpackage

// File: rtl/dsa_ctrl.sv
module dsa_ctrl
  import dsa_pkg::*;
#(
  parameter int DIGIT_W = 2,
  parameter int WORD_W  = 8
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    firstDigit,
  input  logic    lastDigit,
  output strobe_t strobe
);

  localparam int DIGITS_PER_WORD = WORD_W / DIGIT_W;

  always_comb begin
    strobe.wordStart = firstDigit;
    strobe.signLoad  = lastDigit;
  end

  // R1: with multi-digit words, a first digit is never immediately followed
  // by another first digit.
  generate
    if (DIGITS_PER_WORD > 1) begin : g_frame_chk
      p_frame_spacing_r1 : assert property (@(posedge clk) disable iff (rst)
        firstDigit |=> !firstDigit);
    end
  endgenerate

endmodule

// File: rtl/dsa_cell.sv
module dsa_cell #(
  parameter int DIGIT_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               carrySel,    // first digit: use lowerCarry
  input  logic               lowerCarry,  // registered carry of the cell below
  input  logic [DIGIT_W-1:0] addend,
  input  logic [DIGIT_W-1:0] partial,
  output logic [DIGIT_W-1:0] sumQ,
  output logic               carryQ
);

  logic               carryIn;
  logic [DIGIT_W:0]   total;

  always_comb begin
    carryIn = carrySel ? lowerCarry : carryQ;
    total   = {1'b0, addend} + {1'b0, partial} + {{DIGIT_W{1'b0}}, carryIn};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sumQ   <= '0;
      carryQ <= 1'b0;
    end else begin
      sumQ   <= total[DIGIT_W-1:0];
      carryQ <= total[DIGIT_W];
    end
  end

  // R3: two zero operands plus any single carry can never produce a carry.
  p_carry_bound_r3 : assert property (@(posedge clk) disable iff (rst)
    (addend == '0 && partial == '0) |=> !carryQ);

  // R8: reset empties the cell on the next edge.
  p_reset_clear_r8 : assert property (@(posedge clk)
    rst |=> (sumQ == '0 && !carryQ));

endmodule

// File: rtl/dsa_datapath.sv
module dsa_datapath
  import dsa_pkg::*;
#(
  parameter int DIGIT_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  strobe_t            strobe,
  input  logic [DIGIT_W-1:0] prodLow,
  input  logic [DIGIT_W-1:0] prodHigh,
  input  logic [DIGIT_W-1:0] partLow,
  input  logic [DIGIT_W-1:0] partMid,
  input  logic [DIGIT_W-1:0] partHigh,
  output logic [DIGIT_W-1:0] sumLow,
  output logic [DIGIT_W-1:0] sumMid,
  output logic [DIGIT_W-1:0] sumHigh
);

  logic                signLatch;
  logic [DIGIT_W-1:0]  addendVec  [CELL_COUNT];
  logic [DIGIT_W-1:0]  partialVec [CELL_COUNT];
  logic [DIGIT_W-1:0]  sumVec     [CELL_COUNT];
  logic [CELL_COUNT-1:0] carryVec;

  // Sign of the double-precision product, held for the top cell's next word.
  always_ff @(posedge clk) begin
    if (rst)                  signLatch <= 1'b0;
    else if (strobe.signLoad) signLatch <= prodHigh[DIGIT_W-1];
  end

  always_comb begin
    addendVec[0]  = prodLow;
    addendVec[1]  = prodHigh;
    addendVec[2]  = {DIGIT_W{signLatch}};
    partialVec[0] = partLow;
    partialVec[1] = partMid;
    partialVec[2] = partHigh;
  end

  generate
    for (genvar i = 0; i < CELL_COUNT; i++) begin : g_cell
      logic belowCarry;
      if (i == 0) begin : g_base
        assign belowCarry = 1'b0;
      end else begin : g_chain
        assign belowCarry = carryVec[i-1];
      end
      dsa_cell #(.DIGIT_W(DIGIT_W)) u_cell (
        .clk        (clk),
        .rst        (rst),
        .carrySel   (strobe.wordStart),
        .lowerCarry (belowCarry),
        .addend     (addendVec[i]),
        .partial    (partialVec[i]),
        .sumQ       (sumVec[i]),
        .carryQ     (carryVec[i])
      );
    end
  endgenerate

  assign sumLow  = sumVec[0];
  assign sumMid  = sumVec[1];
  assign sumHigh = sumVec[2];

  // R4: the low cell discards any carry left over from the previous word.
  p_low_start_r4 : assert property (@(posedge clk) disable iff (rst)
    (strobe.wordStart && prodLow == '0 && partLow == '0) |=> sumLow == '0);

  // R6: the sign latch changes only on a last-digit strobe.
  p_sign_hold_r6 : assert property (@(posedge clk) disable iff (rst)
    !strobe.signLoad |=> $stable(signLatch));

  // R6: on a last digit the latch takes the product high word's MSB.
  p_sign_load_r6 : assert property (@(posedge clk) disable iff (rst)
    strobe.signLoad |=> signLatch == $past(prodHigh[DIGIT_W-1]));

endmodule

// File: rtl/dsa_accum.sv
module dsa_accum
  import dsa_pkg::*;
#(
  parameter int DIGIT_W = 2,
  parameter int WORD_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               firstDigit,
  input  logic               lastDigit,
  input  logic [DIGIT_W-1:0] prodLowDigit,
  input  logic [DIGIT_W-1:0] prodHighDigit,
  input  logic [DIGIT_W-1:0] partLowDigit,
  input  logic [DIGIT_W-1:0] partMidDigit,
  input  logic [DIGIT_W-1:0] partHighDigit,
  output logic [DIGIT_W-1:0] sumLowDigit,
  output logic [DIGIT_W-1:0] sumMidDigit,
  output logic [DIGIT_W-1:0] sumHighDigit
);

  strobe_t strobe;

  dsa_ctrl #(.DIGIT_W(DIGIT_W), .WORD_W(WORD_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .firstDigit (firstDigit),
    .lastDigit  (lastDigit),
    .strobe     (strobe)
  );

  dsa_datapath #(.DIGIT_W(DIGIT_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .prodLow  (prodLowDigit),
    .prodHigh (prodHighDigit),
    .partLow  (partLowDigit),
    .partMid  (partMidDigit),
    .partHigh (partHighDigit),
    .sumLow   (sumLowDigit),
    .sumMid   (sumMidDigit),
    .sumHigh  (sumHighDigit)
  );

endmodule

// File: tb/sim_dsa_accum.sv
module sim_dsa_accum;

  localparam int CLK_PERIOD = 10;
  localparam int DIGIT_W    = 2;
  localparam int WORD_W     = 8;
  localparam int P          = WORD_W / DIGIT_W;
  localparam int MAXS       = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic firstDigit = 1'b0, lastDigit = 1'b0;
  logic [DIGIT_W-1:0] prodLowDigit = '0, prodHighDigit = '0;
  logic [DIGIT_W-1:0] partLowDigit = '0, partMidDigit = '0, partHighDigit = '0;
  logic [DIGIT_W-1:0] sumLowDigit, sumMidDigit, sumHighDigit;

  int checks = 0;
  int fails  = 0;

  logic [15:0] prodArr [MAXS];
  logic [23:0] partArr [MAXS];
  logic [23:0] gotArr  [MAXS];

  always #(CLK_PERIOD/2) clk = ~clk;

  dsa_accum #(.DIGIT_W(DIGIT_W), .WORD_W(WORD_W)) u0 (
    .clk(clk), .rst(rst), .firstDigit(firstDigit), .lastDigit(lastDigit),
    .prodLowDigit(prodLowDigit), .prodHighDigit(prodHighDigit),
    .partLowDigit(partLowDigit), .partMidDigit(partMidDigit),
    .partHighDigit(partHighDigit), .sumLowDigit(sumLowDigit),
    .sumMidDigit(sumMidDigit), .sumHighDigit(sumHighDigit)
  );

  task automatic check(input string req, input logic [23:0] got, input logic [23:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%06h expected=%06h", req, got, exp);
    end
  endtask

  // Streams samples 0..m-1 with the R5 skew, two extra periods to drain.
  task automatic runStream(input int m);
    for (int k = 0; k < m + 2; k++) begin
      for (int d = 0; d < P; d++) begin
        @(negedge clk);
        firstDigit    = (d == 0);
        lastDigit     = (d == P - 1);
        prodLowDigit  = (k < m) ? prodArr[k][d*DIGIT_W +: DIGIT_W] : '0;
        partLowDigit  = (k < m) ? partArr[k][d*DIGIT_W +: DIGIT_W] : '0;
        prodHighDigit = (k >= 1 && k - 1 < m) ? prodArr[k-1][8 + d*DIGIT_W +: DIGIT_W] : '0;
        partMidDigit  = (k >= 1 && k - 1 < m) ? partArr[k-1][8 + d*DIGIT_W +: DIGIT_W] : '0;
        partHighDigit = (k >= 2 && k - 2 < m) ? partArr[k-2][16 + d*DIGIT_W +: DIGIT_W] : '0;
        @(posedge clk);
        #1;
        if (k < m)                gotArr[k][d*DIGIT_W +: DIGIT_W]        = sumLowDigit;
        if (k >= 1 && k - 1 < m)  gotArr[k-1][8 + d*DIGIT_W +: DIGIT_W]  = sumMidDigit;
        if (k >= 2 && k - 2 < m)  gotArr[k-2][16 + d*DIGIT_W +: DIGIT_W] = sumHighDigit;
      end
    end
  endtask

  task automatic checkAll(input string req, input int m);
    for (int s = 0; s < m; s++)
      check(req, gotArr[s], partArr[s] + {{8{prodArr[s][15]}}, prodArr[s]});
  endtask

  // R8 reset state, R2 one-cycle latency.
  task automatic testResetLatency();
    rst = 1'b1;
    prodLowDigit = '1; partLowDigit = '1; partMidDigit = '1; partHighDigit = '1;
    prodHighDigit = '1; firstDigit = 1'b1; lastDigit = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R8 reset clears sums", {sumHighDigit, sumMidDigit, sumLowDigit}, '0);
    @(negedge clk);
    rst = 1'b0;
    prodLowDigit = 1; partLowDigit = 0; prodHighDigit = 0; partMidDigit = 0;
    partHighDigit = 0; firstDigit = 1'b1; lastDigit = (P == 1);
    @(posedge clk);
    #1;
    check("R2 latency one clock", {22'd0, sumLowDigit[1:0]}, 24'd1);
    for (int d = 1; d < P; d++) begin
      @(negedge clk);
      prodLowDigit = 0; firstDigit = 1'b0; lastDigit = (d == P - 1);
    end
    prodArr[0] = 0; partArr[0] = 0;
    runStream(1);
  endtask

  // R3/R4/R7: carry ripples within words, across cells, and wraps.
  task automatic testCarryChain();
    prodArr[0] = 16'h0001; partArr[0] = 24'h00FFFF;   // R4 -> 010000
    prodArr[1] = 16'h00FF; partArr[1] = 24'h000001;   // R3 -> 000100
    prodArr[2] = 16'h0001; partArr[2] = 24'hFFFFFF;   // R7 wrap -> 000000
    prodArr[3] = 16'h7FFF; partArr[3] = 24'h7F8001;   // R4 both boundaries
    runStream(4);
    check("R4 ripple into top", gotArr[0], 24'h010000);
    check("R3 ripple in word",  gotArr[1], 24'h000100);
    check("R7 modulo wrap",     gotArr[2], 24'h000000);
    checkAll("R4 carry chain", 4);
  endtask

  // R6: negative products need the latched sign in the top byte.
  task automatic testSign();
    prodArr[0] = 16'hFFFF; partArr[0] = 24'h000000;
    prodArr[1] = 16'h8000; partArr[1] = 24'h000000;
    prodArr[2] = 16'h7FFF; partArr[2] = 24'h000000;
    prodArr[3] = 16'hFFFF; partArr[3] = 24'h000001;
    prodArr[4] = 16'h0000; partArr[4] = 24'h123456;
    prodArr[5] = 16'h8001; partArr[5] = 24'h00FFFF;
    runStream(6);
    check("R6 minus one",     gotArr[0], 24'hFFFFFF);
    check("R6 most negative", gotArr[1], 24'hFF8000);
    check("R6 positive after negative", gotArr[2], 24'h007FFF);
    checkAll("R6 alternating signs", 6);
  endtask

  // R1/R5: random back-to-back samples.
  task automatic testRandom();
    for (int r = 0; r < 20; r++) begin
      for (int s = 0; s < 12; s++) begin
        prodArr[s] = 16'($urandom);
        partArr[s] = 24'($urandom);
      end
      runStream(12);
      checkAll("R5 random stream", 12);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog run did not complete");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(7));
    testResetLatency();
    testCarryChain();
    testSign();
    testRandom();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule